// File: doc/BRIEF.md
# Filtered Edge-Capture Timer

This block is a 16-bit up-counter with a single capture register, intended for measuring how long an external signal stays high or low. The counter advances on a prescaled count enable. When a qualified transition arrives on the external input, the running count is copied into the capture register and a one-cycle interrupt-request pulse is raised.

The external input is first brought into the system clock domain by a two-flop synchronizer. It then passes through a noise filter that samples only on count-enable cycles. A change of level is accepted only when two successive samples both show the new level, so shorter disturbances are discarded. Software programs a control word that sets the prescaler, which edges are valid, whether the counter runs, and whether the second register captures. It reads the captured value and a sticky overflow flag directly from output ports. For a pulse-width measurement, both edges are selected and the earlier capture is subtracted from the later one. The result is valid only while the pulse is shorter than one full counter period; a longer pulse is revealed only by the overflow flag.

Top module: `edge_capture_timer`

## Requirements
- R1: While the mode field (control bits [5:4]) equals 01, the count increases by one on every count-enable cycle and wraps from 0xFFFF to 0x0000.
- R2: On an accepted capture, the capture register takes the count value present in the cycle before the write, and it changes at no other time.
- R3: Each capture raises `irq` for exactly one system-clock cycle, in the same cycle that the capture register is updated.
- R4: The edge-select field (control bits [3:2]) works as follows: 01 selects rising edges, 10 selects falling edges, 11 selects both, and 00 selects neither.
- R5: A new input level is accepted only after it appears on two consecutive count-enable samples, so a pulse seen on just one sample causes no capture.
- R6: The clock-select field (control bits [1:0]) works as follows: 00 gives a count enable on every cycle, 01 on every 4th cycle, and 10 on every 16th cycle. The disallowed code 11 behaves like 10.
- R7: When the count wraps, `ovf_flag` is set and stays set. Writing address 1 with bit 0 equal to 0 clears it, and writing bit 0 equal to 1 leaves it unchanged.
- R8: When the mode field is not 01, the count is held at zero and no capture or `irq` occurs.
- R9: When the capture-enable bit (control bit 6) is 0, no capture or `irq` occurs.
- R10: After a synchronous reset, the count, the capture register, `irq` and `ovf_flag` are all 0, and the control word is 0, which means stopped.
- R11: With both edges selected, the difference between the falling-edge capture and the rising-edge capture equals the pulse width divided by the count-enable period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0: control word, 1: overflow flag |
| cfg_wdata | input | 8 | Write data |
| ext_in | input | 1 | External input being measured |
| count_value | output | 16 | Current counter value |
| cap_value | output | 16 | Capture register |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Capture interrupt-request pulse |

## Verification
The bench sends glitches that are shorter than two sample periods at the divide-by-1 and divide-by-4 rates. A filter that accepted a single sample would capture on these glitches and pulse `irq`. It measures known pulse widths at each prescaler code, including the disallowed one. An off-by-one in the capture timing, or a prescaler that ignored code 11, would show up as a wrong difference between captures. It also runs the counter through a full wrap to check that the overflow flag sets, stays set when 1 is written, and clears only when 0 is written. Stopped mode and capture-disabled mode are tested with input activity present, so that a leaked capture would appear on `irq` or `cap_value`.

// File: rtl/ect_pkg.sv
package ect_pkg;
  typedef enum logic [1:0] {
    CS_DIV1  = 2'b00,
    CS_DIV4  = 2'b01,
    CS_DIV16 = 2'b10,
    CS_RSVD  = 2'b11
  } clk_sel_e;

  localparam logic [1:0] MODE_RUN = 2'b01;

  typedef struct packed {
    logic       cap_en;
    logic [1:0] mode;
    logic [1:0] edge_sel;
    clk_sel_e   clk_sel;
  } ctrl_t;
endpackage

// File: rtl/ect_prescaler.sv
module ect_prescaler
  import ect_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  clk_sel_e sel,
  output logic     tick
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (sel)
      CS_DIV1:  tick = 1'b1;
      CS_DIV4:  tick = &div_q[1:0];
      default:  tick = &div_q[3:0];
    endcase
  end
endmodule

// File: rtl/ect_filter.sv
module ect_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic samp_q, stable_q, synced;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= din;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q   <= 1'b0;
      stable_q <= 1'b0;
      rise     <= 1'b0;
      fall     <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (tick) begin
        samp_q <= synced;
        if (synced == samp_q && synced != stable_q) begin
          stable_q <= synced;
          rise     <= synced;
          fall     <= ~synced;
        end
      end
    end
  end
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic wrap;

  assign wrap = run && tick && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (!run)      count <= '0;
      else if (tick) count <= count + 1'b1;
      if (wrap)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [7:0]       cfg_wdata,
  input  logic             ext_in,
  output logic [CNT_W-1:0] count_value,
  output logic [CNT_W-1:0] cap_value,
  output logic             ovf_flag,
  output logic             irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl_q;
  logic  tick, rise, fall, run, hit, ovf_clr;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (cfg_we && !cfg_addr) ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
  end

  assign run     = (ctrl_q.mode == MODE_RUN);
  assign ovf_clr = cfg_we && cfg_addr && !cfg_wdata[0];

  ect_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel(ctrl_q.clk_sel), .tick(tick)
  );

  ect_filter #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
    .clk(clk), .rst(rst), .tick(tick), .din(ext_in), .rise(rise), .fall(fall)
  );

  ect_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .ovf_clr(ovf_clr),
    .count(count_value), .ovf(ovf_flag)
  );

  assign hit = run && ctrl_q.cap_en &&
               ((rise && ctrl_q.edge_sel[0]) || (fall && ctrl_q.edge_sel[1]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= hit;
      if (hit) cap_value <= count_value;
    end
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic [CNT_W-1:0] count_value,
  input logic [CNT_W-1:0] cap_value,
  input logic             ovf_flag,
  input logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  a_r3_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r2_cap_only_on_irq: assert property (@(posedge clk) disable iff (rst)
    !irq |-> $stable(cap_value));

  a_r8_stopped_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count_value == '0));

  a_r8_stopped_no_irq: assert property (@(posedge clk) disable iff (rst)
    !run |=> !irq);

  a_r7_ovf_on_wrap: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(count_value) == CNT_MAX && count_value == '0));

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (count_value != $past(count_value)) |->
      (count_value == $past(count_value) + 1'b1 || count_value == '0));
endmodule

bind edge_capture_timer ect_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .count_value(count_value),
  .cap_value(cap_value), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/sim_edge_capture_timer.sv
`timescale 1ns/1ps
module sim_edge_capture_timer;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic        cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        ext_in = 0;
  logic [15:0] count_value, cap_value;
  logic        ovf_flag, irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int irq_seen = 0;
  bit done = 0;
  int caps[$];

  always #2.5 clk = ~clk;

  edge_capture_timer u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ext_in(ext_in), .count_value(count_value),
    .cap_value(cap_value), .ovf_flag(ovf_flag), .irq(irq)
  );

  // behavioural reference model
  int m_ctrl, m_pc, m_cnt, m_cap, m_s1, m_s2, m_samp, m_stab, m_er, m_ef;
  bit m_irq, m_ovf;

  always @(posedge clk) begin
    int sel, mode, esel, tk, run, nr, nf, hit, oc;
    if (rst) begin
      m_ctrl = 0; m_pc = 0; m_cnt = 0; m_cap = 0; m_s1 = 0; m_s2 = 0;
      m_samp = 0; m_stab = 0; m_er = 0; m_ef = 0; m_irq = 0; m_ovf = 0;
    end else begin
      sel  = m_ctrl % 4;
      esel = (m_ctrl / 4) % 4;
      mode = (m_ctrl / 16) % 4;
      run  = (mode == 1);
      tk   = (sel == 0) ? 1 : (sel == 1) ? (m_pc % 4 == 3) : (m_pc % 16 == 15);
      m_pc = (m_pc + 1) % 16;
      hit  = run && ((m_ctrl / 64) % 2 == 1) &&
             ((m_er && esel % 2 == 1) || (m_ef && esel / 2 == 1));
      m_irq = hit;
      if (hit) m_cap = m_cnt;
      nr = 0; nf = 0;
      if (tk) begin
        if (m_s2 == m_samp && m_s2 != m_stab) begin
          nr = m_s2; nf = !m_s2; m_stab = m_s2;
        end
        m_samp = m_s2;
      end
      m_er = nr; m_ef = nf;
      m_s2 = m_s1; m_s1 = ext_in;
      oc = cfg_we && cfg_addr && !cfg_wdata[0];
      if (!run) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == 65535) begin m_cnt = 0; m_ovf = 1; oc = 0; end
        else m_cnt = m_cnt + 1;
      end
      if (oc) m_ovf = 0;
      if (cfg_we && !cfg_addr) m_ctrl = cfg_wdata[6:0];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      cycles++;
      check("R1 count", count_value, m_cnt);
      check("R2 capture", cap_value, m_cap);
      check("R3 irq", irq, m_irq);
      check("R7 overflow", ovf_flag, m_ovf);
      if (irq) begin irq_seen++; caps.push_back(cap_value); end
    end
  end

  task automatic cfg(input bit a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d[7:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk);
    ext_in = 1;
    repeat (hi) @(negedge clk);
    ext_in = 0;
    repeat (lo) @(negedge clk);
  endtask

  // control word: [1:0] clk sel, [3:2] edge sel, [5:4] mode, [6] capture enable
  function automatic int cw(int sel, int esel, int mode, int en);
    return sel + esel * 4 + mode * 16 + en * 64;
  endfunction

  task automatic width_test(input string req, input int sel, input int w, input int exp);
    caps.delete();
    cfg(0, cw(sel, 3, 1, 1));
    pulse(w, w + 80);
    check(req, caps.size(), 2);
    if (caps.size() == 2) check(req, (caps[1] - caps[0]) & 16'hFFFF, exp);
  endtask

  initial begin : wdog
    while (cycles < 190000 && !done) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 count", count_value, 0);
    check("R10 cap", cap_value, 0);
    check("R10 irq", irq, 0);
    check("R10 ovf", ovf_flag, 0);
    repeat (5) @(negedge clk);
    check("R10 stopped", count_value, 0);

    // R4 rising only
    cfg(0, cw(0, 1, 1, 1));
    n = irq_seen; pulse(10, 20);
    check("R4 rising", irq_seen - n, 1);
    // R4 falling only
    cfg(0, cw(0, 2, 1, 1));
    n = irq_seen; pulse(10, 20);
    check("R4 falling", irq_seen - n, 1);
    // R4 both
    cfg(0, cw(0, 3, 1, 1));
    n = irq_seen; pulse(10, 20);
    check("R4 both", irq_seen - n, 2);
    // R4 neither
    cfg(0, cw(0, 0, 1, 1));
    n = irq_seen; pulse(10, 20);
    check("R4 none", irq_seen - n, 0);

    // R5 glitches: one cycle at div1, two cycles at div4
    cfg(0, cw(0, 3, 1, 1));
    n = irq_seen; pulse(1, 20);
    check("R5 glitch div1", irq_seen - n, 0);
    cfg(0, cw(1, 3, 1, 1));
    n = irq_seen;
    for (int i = 0; i < 4; i++) begin
      repeat (i) @(negedge clk);
      pulse(2, 30);
    end
    check("R5 glitch div4", irq_seen - n, 0);

    // R11 / R6 widths at each prescaler code
    width_test("R11 div1", 0, 37, 37);
    width_test("R6 div4", 1, 40, 10);
    width_test("R6 div16", 2, 160, 10);
    width_test("R6 code11", 3, 160, 10);

    // R8 stopped mode
    cfg(0, cw(0, 3, 0, 1));
    n = irq_seen; pulse(10, 20);
    check("R8 no irq", irq_seen - n, 0);
    check("R8 count zero", count_value, 0);

    // R9 capture disabled
    cfg(0, cw(0, 3, 1, 1));
    pulse(10, 20);
    n = irq_seen;
    cfg(0, cw(0, 3, 1, 0));
    caps.delete();
    pulse(10, 20);
    check("R9 no irq", irq_seen - n, 0);

    // R7 overflow through a full wrap
    cfg(0, cw(0, 3, 0, 0));
    cfg(0, cw(0, 0, 1, 0));
    repeat (65540) @(negedge clk);
    check("R7 set", ovf_flag, 1);
    check("R1 wrapped", count_value < 16'd100, 1);
    cfg(1, 1);
    check("R7 write1 keeps", ovf_flag, 1);
    cfg(1, 0);
    check("R7 write0 clears", ovf_flag, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule